// File: doc/BRIEF.md
# Fast 4x4 Intra Prediction Mode Selector

This block picks the 4x4 luma intra prediction mode for each 4x4 block of a 16x16 macroblock. Each candidate mode is scored by a cost made of two parts. The first is the Hadamard-based SATD of the residual between the original pixels and the predictor. The second is a lambda-weighted penalty for signalling the mode. The block asks an outside predictor generator for one mode's predictor pixels at a time. It scores that mode in the cycle the pixels arrive and keeps the cheapest mode found so far.

Blocks in the first column of each block row are searched over all nine modes. The minimum SATD found on these blocks is kept for the macroblock. Every other block is scored only over a small candidate set: the two neighbour modes plus DC. In that reduced search the residual is subsampled, with the odd columns replaced by copies of their even neighbours. If the best subsampled SATD of such a block exceeds twice the macroblock minimum, the block is scored again over all nine modes with the full residual. When scoring is finished, the chosen mode and its cost are presented with a one-cycle done pulse.

Top module: `intra4_mode_sel`

## Requirements
- R1: After reset, reqValid and done are low.
- R2: A block whose index has bits [1:0] equal to 0 requests all nine modes, 0 through 8, once each in ascending order, and is scored on the full residual.
- R3: Any other block requests only the set {left, top, 2}, in ascending order without repeats. A neighbour whose avail input is low counts as mode 2 (DC).
- R4: The cost of a mode is SATD + lambda when the mode equals the most probable mode, and SATD + 4*lambda otherwise. The most probable mode is min(left, top) when both neighbours are available, and 2 otherwise.
- R5: SATD is the sum of the absolute values of the 4x4 Hadamard transform of (original - predictor), divided by 2 with truncation. Pixel (row y, column x) sits at bits [(4y+x)*8 +: 8] of both pixel buses.
- R6: In the reduced search, the residual at columns 1 and 3 is replaced by the residual at columns 0 and 2 of the same row before the transform.
- R7: When two modes have equal cost, the lower mode number is chosen.
- R8: When the best subsampled SATD of a reduced search is strictly greater than twice the full-search minimum, all nine modes are requested again in ascending order. The result then comes from this full-residual pass alone. A best SATD equal to twice the minimum does not trigger this.
- R9: The full-search minimum is the smallest chosen-mode SATD among the full-searched blocks since the last block with index 0. It is cleared when a block with index 0 starts, so a block from an earlier macroblock does not affect it.
- R10: done is high for exactly one cycle, after the last candidate has been scored. bestMode and bestCost hold the result from then until the next accepted start.
- R11: reqValid and reqMode are held until predValid is seen. A start asserted while a block is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block; accepted only when idle |
| blkIdx | input | 4 | Raster index of the 4x4 block in the macroblock |
| origPix | input | 128 | Original 4x4 pixels |
| leftMode | input | 4 | Mode chosen for the left neighbour block |
| leftAvail | input | 1 | Left neighbour mode is valid |
| topMode | input | 4 | Mode chosen for the upper neighbour block |
| topAvail | input | 1 | Upper neighbour mode is valid |
| lambda | input | 8 | Rate weight |
| reqValid | output | 1 | Predictor requested |
| reqMode | output | 4 | Mode whose predictor is requested |
| predValid | input | 1 | Predictor pixels present on predPix |
| predPix | input | 128 | Predictor pixels for reqMode |
| done | output | 1 | One-cycle pulse: result ready |
| bestMode | output | 4 | Chosen mode |
| bestCost | output | 17 | Cost of the chosen mode |

## Verification
Predictors are built as the original pixels plus a per-mode offset of chosen size. Setting the offset to zero for one mode forces a zero-SATD winner, which fixes the full-search minimum at zero. Two cases then separate the threshold test. A reduced block with a zero-SATD candidate sits on the equality boundary and must not re-search. A noisy reduced block must re-search. A predictor that differs from the original only in odd columns gives a zero subsampled SATD but a non-zero full SATD, which separates the subsampled path from the full one. All-zero offsets with a lambda of zero separate the tie rule. A new macroblock with noisy predictors shows whether the minimum was cleared, and random sweeps over all block positions and neighbour pairs cover the candidate sets and the most probable mode rule.

// File: rtl/ims_pkg.sv
package ims_pkg;
  localparam int NUM_MODES = 9;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] DC_MODE = 4'd2;

  typedef struct packed {
    logic              load;       // latch the block inputs
    logic              firstBlk;   // block opens a new macroblock
    logic              clearBest;  // restart the best-cost search
    logic              score;      // predictor present, evaluate mode
    logic              useSub;     // subsampled residual
    logic              commitMin;  // fold best SATD into the full-search minimum
    logic [MODE_W-1:0] mode;
    logic [MODE_W-1:0] mpm;
  } ctlStrobe_t;
endpackage

// File: rtl/ims_satd.sv
module ims_satd #(
  parameter int PIX_W = 8,
  parameter bit SUB_ROWS = 1'b0,
  localparam int RES_W = PIX_W + 1,
  localparam int HAD_W = RES_W + 4,
  localparam int SUM_W = HAD_W + 4,
  localparam int SATD_W = SUM_W - 1
) (
  input  logic [16*PIX_W-1:0] origPix,
  input  logic [16*PIX_W-1:0] predPix,
  input  logic                useSub,
  output logic [SATD_W-1:0]   satd
);
  logic signed [HAD_W-1:0] diff   [16];
  logic signed [HAD_W-1:0] picked [16];
  logic signed [HAD_W-1:0] rowT   [16];
  logic signed [HAD_W-1:0] colT   [16];
  logic        [HAD_W-1:0] absVal [16];
  logic        [SUM_W-1:0] acc;

  for (genvar g = 0; g < 16; g++) begin : g_res
    localparam int ROW = g / 4;
    localparam int COL = g % 4;
    localparam int SRC = SUB_ROWS ? ((ROW / 2) * 8 + COL) : (ROW * 4 + (COL / 2) * 2);
    assign diff[g] = $signed({1'b0, origPix[g*PIX_W +: PIX_W]})
                   - $signed({1'b0, predPix[g*PIX_W +: PIX_W]});
    assign picked[g] = useSub ? diff[SRC] : diff[g];
  end

  for (genvar r = 0; r < 4; r++) begin : g_rows
    logic signed [HAD_W-1:0] s01, s23, d01, d23;
    assign s01 = picked[r*4+0] + picked[r*4+1];
    assign s23 = picked[r*4+2] + picked[r*4+3];
    assign d01 = picked[r*4+0] - picked[r*4+1];
    assign d23 = picked[r*4+2] - picked[r*4+3];
    assign rowT[r*4+0] = s01 + s23;
    assign rowT[r*4+1] = s01 - s23;
    assign rowT[r*4+2] = d01 - d23;
    assign rowT[r*4+3] = d01 + d23;
  end

  for (genvar c = 0; c < 4; c++) begin : g_cols
    logic signed [HAD_W-1:0] s01, s23, d01, d23;
    assign s01 = rowT[c] + rowT[4+c];
    assign s23 = rowT[8+c] + rowT[12+c];
    assign d01 = rowT[c] - rowT[4+c];
    assign d23 = rowT[8+c] - rowT[12+c];
    assign colT[c]    = s01 + s23;
    assign colT[4+c]  = s01 - s23;
    assign colT[8+c]  = d01 - d23;
    assign colT[12+c] = d01 + d23;
  end

  for (genvar a = 0; a < 16; a++) begin : g_abs
    assign absVal[a] = colT[a][HAD_W-1] ? HAD_W'(-colT[a]) : HAD_W'(colT[a]);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < 16; i++) acc = acc + SUM_W'(absVal[i]);
  end

  assign satd = acc[SUM_W-1:1];
endmodule

// File: rtl/ims_datapath.sv
module ims_datapath
  import ims_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LAM_W = 8,
  parameter bit SUB_ROWS = 1'b0,
  localparam int BLK_W = 16 * PIX_W,
  localparam int SATD_W = PIX_W + 8,
  localparam int COST_W = SATD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [BLK_W-1:0]  origIn,
  input  logic [LAM_W-1:0]  lambdaIn,
  input  logic [BLK_W-1:0]  predPix,
  output logic              needFull,
  output logic [MODE_W-1:0] bestMode,
  output logic [COST_W-1:0] bestCost
);
  logic [BLK_W-1:0]  origReg;
  logic [LAM_W-1:0]  lamReg;
  logic [SATD_W-1:0] fullMin;
  logic [SATD_W-1:0] bestSatd;
  logic [SATD_W-1:0] satdNow;
  logic [COST_W-1:0] rateTerm;
  logic [COST_W-1:0] costNow;

  ims_satd #(.PIX_W(PIX_W), .SUB_ROWS(SUB_ROWS)) u_satd (
    .origPix(origReg),
    .predPix(predPix),
    .useSub (ctl.useSub),
    .satd   (satdNow)
  );

  assign rateTerm = (ctl.mode == ctl.mpm) ? COST_W'(lamReg) : (COST_W'(lamReg) << 2);
  assign costNow  = COST_W'(satdNow) + rateTerm;
  assign needFull = {1'b0, bestSatd} > {fullMin, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      origReg <= '0;
      lamReg  <= '0;
      fullMin <= '1;
    end else begin
      if (ctl.load) begin
        origReg <= origIn;
        lamReg  <= lambdaIn;
        if (ctl.firstBlk) fullMin <= '1;
      end else if (ctl.commitMin && bestSatd < fullMin) begin
        fullMin <= bestSatd;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestMode <= '0;
      bestCost <= '0;
      bestSatd <= '1;
    end else if (ctl.clearBest) begin
      bestMode <= DC_MODE;
      bestCost <= '1;
      bestSatd <= '1;
    end else if (ctl.score && costNow < bestCost) begin
      bestMode <= ctl.mode;
      bestCost <= costNow;
      bestSatd <= satdNow;
    end
  end
endmodule

// File: rtl/ims_control.sv
module ims_control
  import ims_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        blkIdx,
  input  logic [MODE_W-1:0] leftMode,
  input  logic              leftAvail,
  input  logic [MODE_W-1:0] topMode,
  input  logic              topAvail,
  input  logic              predValid,
  input  logic              needFull,
  output logic              reqValid,
  output logic [MODE_W-1:0] reqMode,
  output logic              done,
  output ctlStrobe_t        ctl
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DECIDE, S_FIN} state_t;

  state_t               state;
  logic [NUM_MODES-1:0] candMask;
  logic [MODE_W-1:0]    curMode;
  logic [MODE_W-1:0]    mpmReg;
  logic                 isFull;
  logic                 subActive;

  logic                 accept;
  logic                 fullNew;
  logic [MODE_W-1:0]    leftEff, topEff, mpmNew;
  logic [NUM_MODES-1:0] maskNew;
  logic [MODE_W:0]      firstPick, nextPick;
  logic                 reSearch;

  // lowest set mask bit at or above floorIdx, with a found flag on top
  function automatic logic [MODE_W:0] pickFrom(input logic [NUM_MODES-1:0] m,
                                               input int floorIdx);
    logic [MODE_W:0] res;
    res = '0;
    for (int i = NUM_MODES - 1; i >= 0; i--) begin
      if (m[i] && i >= floorIdx) res = {1'b1, MODE_W'(i)};
    end
    return res;
  endfunction

  assign accept  = (state == S_IDLE) && start;
  assign fullNew = (blkIdx[1:0] == 2'd0);
  assign leftEff = leftAvail ? leftMode : DC_MODE;
  assign topEff  = topAvail ? topMode : DC_MODE;
  assign mpmNew  = (leftAvail && topAvail) ? ((leftMode < topMode) ? leftMode : topMode) : DC_MODE;

  always_comb begin
    if (fullNew) maskNew = '1;
    else maskNew = (NUM_MODES'(1) << leftEff) | (NUM_MODES'(1) << topEff)
                 | (NUM_MODES'(1) << DC_MODE);
  end

  assign firstPick = pickFrom(maskNew, 0);
  assign nextPick  = pickFrom(candMask, int'(curMode) + 1);
  assign reSearch  = (state == S_DECIDE) && subActive && needFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      candMask  <= '0;
      curMode   <= '0;
      mpmReg    <= DC_MODE;
      isFull    <= 1'b0;
      subActive <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          candMask  <= maskNew;
          curMode   <= firstPick[MODE_W-1:0];
          mpmReg    <= mpmNew;
          isFull    <= fullNew;
          subActive <= !fullNew;
          state     <= S_REQ;
        end
        S_REQ: if (predValid) begin
          if (nextPick[MODE_W]) curMode <= nextPick[MODE_W-1:0];
          else state <= S_DECIDE;
        end
        S_DECIDE: begin
          if (reSearch) begin
            candMask  <= '1;
            curMode   <= '0;
            subActive <= 1'b0;
            state     <= S_REQ;
          end else begin
            state <= S_FIN;
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.load      = accept;
    ctl.firstBlk  = (blkIdx == 4'd0);
    ctl.clearBest = accept || reSearch;
    ctl.score     = (state == S_REQ) && predValid;
    ctl.useSub    = subActive;
    ctl.commitMin = (state == S_DECIDE) && !reSearch && isFull;
    ctl.mode      = curMode;
    ctl.mpm       = mpmReg;
  end

  assign reqValid = (state == S_REQ);
  assign reqMode  = curMode;
  assign done     = (state == S_FIN);
endmodule

// File: rtl/intra4_mode_sel.sv
module intra4_mode_sel
  import ims_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LAM_W = 8,
  parameter bit SUB_ROWS = 1'b0,
  localparam int BLK_W = 16 * PIX_W,
  localparam int COST_W = PIX_W + 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        blkIdx,
  input  logic [BLK_W-1:0]  origPix,
  input  logic [MODE_W-1:0] leftMode,
  input  logic              leftAvail,
  input  logic [MODE_W-1:0] topMode,
  input  logic              topAvail,
  input  logic [LAM_W-1:0]  lambda,
  output logic              reqValid,
  output logic [MODE_W-1:0] reqMode,
  input  logic              predValid,
  input  logic [BLK_W-1:0]  predPix,
  output logic              done,
  output logic [MODE_W-1:0] bestMode,
  output logic [COST_W-1:0] bestCost
);
  ctlStrobe_t ctl;
  logic       needFull;

  ims_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .blkIdx(blkIdx),
    .leftMode(leftMode), .leftAvail(leftAvail),
    .topMode(topMode), .topAvail(topAvail),
    .predValid(predValid), .needFull(needFull),
    .reqValid(reqValid), .reqMode(reqMode), .done(done), .ctl(ctl)
  );

  ims_datapath #(.PIX_W(PIX_W), .LAM_W(LAM_W), .SUB_ROWS(SUB_ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .origIn(origPix), .lambdaIn(lambda),
    .predPix(predPix), .needFull(needFull), .bestMode(bestMode), .bestCost(bestCost)
  );
endmodule

// File: rtl/ims_checker.sv
module ims_checker #(
  parameter int COST_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [3:0]        reqMode,
  input logic              predValid,
  input logic              done,
  input logic [3:0]        bestMode,
  input logic [COST_W-1:0] bestCost
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_REQ_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && done)); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(bestMode) && $stable(bestCost))); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !predValid) |=> (reqValid && $stable(reqMode))); // R11
  AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqMode <= 4'd8)); // R2
  AST_REQ_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && predValid) |=> (!reqValid || (reqMode > $past(reqMode)))); // R3
endmodule

bind intra4_mode_sel ims_checker #(.COST_W(COST_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
  .predValid(predValid), .done(done), .bestMode(bestMode), .bestCost(bestCost)
);

// File: tb/test_intra4_mode_sel.sv
module test_intra4_mode_sel;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   blkIdx = '0;
  logic [127:0] origPix = '0;
  logic [3:0]   leftMode = '0, topMode = '0;
  logic         leftAvail = 1'b0, topAvail = 1'b0;
  logic [7:0]   lambda = '0;
  logic         reqValid, done;
  logic [3:0]   reqMode, bestMode;
  logic         predValid = 1'b0;
  logic [127:0] predPix = '0;
  logic [16:0]  bestCost;

  intra4_mode_sel i_intra4_mode_sel (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int curOrig [16];
  int noiseLvl [9];
  int curSeed = 0;
  bit oddOnly = 1'b0;
  int fmin = 1 << 30;
  int reqQ [$];
  int modeQ [$];
  int costQ [$];
  string tagQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int predAt(input int m, input int p);
    int off;
    off = (curSeed * 31 + m * 17 + p * 7 + m * p * 3) % (noiseLvl[m] + 1);
    if (oddOnly && ((p % 4) % 2 == 0)) off = 0;
    return curOrig[p] + off;
  endfunction

  function automatic int hs(input int a, input int b);
    return ($countones(a & b) % 2) ? -1 : 1;
  endfunction

  function automatic int satdRef(input int m, input bit sub);
    int d [16];
    int s;
    s = 0;
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++) begin
        int sx;
        sx = sub ? (x / 2) * 2 : x;
        d[y*4+x] = curOrig[y*4+sx] - predAt(m, y*4+sx);
      end
    for (int u = 0; u < 4; u++)
      for (int v = 0; v < 4; v++) begin
        int acc;
        acc = 0;
        for (int y = 0; y < 4; y++)
          for (int x = 0; x < 4; x++) acc += hs(u, y) * hs(v, x) * d[y*4+x];
        s += (acc < 0) ? -acc : acc;
      end
    return s / 2;
  endfunction

  task automatic setNoise(input int lvl);
    for (int i = 0; i < 9; i++) noiseLvl[i] = lvl;
  endtask

  // Driver: builds expected requests and result, then launches the block
  task automatic runBlock(input int idx, input int lm, input bit la, input int tm,
                          input bit ta, input int lam, input int seed,
                          input string tag, input bit intrude);
    int mask, mpm, bm, bc, bs, le, te;
    bit full;
    curSeed = seed;
    for (int p = 0; p < 16; p++) curOrig[p] = 20 + ((seed * 13 + p * 29 + p * p) % 180);
    full = (idx % 4) == 0;
    le = la ? lm : 2;
    te = ta ? tm : 2;
    mask = full ? 9'h1FF : ((1 << le) | (1 << te) | (1 << 2));
    mpm = (la && ta) ? ((lm < tm) ? lm : tm) : 2;
    if (idx == 0) fmin = 1 << 30;
    bc = 1 << 30; bm = 0; bs = 0;
    for (int m = 0; m < 9; m++)
      if (mask[m]) begin
        int s, c;
        reqQ.push_back(m);
        s = satdRef(m, !full);
        c = s + lam * ((m == mpm) ? 1 : 4);
        if (c < bc) begin bc = c; bm = m; bs = s; end
      end
    if (!full && bs > 2 * fmin) begin
      bc = 1 << 30;
      for (int m = 0; m < 9; m++) begin
        int s, c;
        reqQ.push_back(m);
        s = satdRef(m, 1'b0);
        c = s + lam * ((m == mpm) ? 1 : 4);
        if (c < bc) begin bc = c; bm = m; bs = s; end
      end
    end
    if (full && bs < fmin) fmin = bs;
    modeQ.push_back(bm); costQ.push_back(bc); tagQ.push_back(tag);

    @(negedge clk);
    blkIdx = 4'(idx); leftMode = 4'(lm); leftAvail = la; topMode = 4'(tm); topAvail = ta;
    lambda = 8'(lam);
    for (int p = 0; p < 16; p++) origPix[p*8 +: 8] = 8'(curOrig[p]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      @(negedge clk);
      blkIdx = 4'd0; origPix = {16{8'hFF}}; lambda = 8'd200; start = 1'b1;  // R11 ignored start
      @(negedge clk);
      start = 1'b0;
    end
    while (modeQ.size() != 0 && !finished) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: acts as predictor source and compares against the queues
  initial begin
    int reqCount, heldMode;
    bit stalled, prevDone;
    reqCount = 0; stalled = 1'b0; prevDone = 1'b0; heldMode = 0;
    forever begin
      @(negedge clk);
      if (prevDone) check(!done, "R10 done pulse width", int'(done), 0);
      prevDone = done;
      if (done) begin
        if (modeQ.size() == 0) check(1'b0, "R10 unexpected done", 1, 0);
        else begin
          int em, ec;
          string tg;
          em = modeQ.pop_front(); ec = costQ.pop_front(); tg = tagQ.pop_front();
          check(int'(bestMode) == em, {tg, " mode"}, int'(bestMode), em);
          check(int'(bestCost) == ec, {tg, " cost R4"}, int'(bestCost), ec);
        end
      end
      if (reqValid) begin
        reqCount++;
        if (reqCount % 3 == 0 && !stalled) begin
          predValid = 1'b0; stalled = 1'b1; heldMode = int'(reqMode);
        end else begin
          if (stalled) check(int'(reqMode) == heldMode, "R11 request held", int'(reqMode), heldMode);
          stalled = 1'b0;
          if (reqQ.size() == 0) check(1'b0, "R2 R3 extra request", int'(reqMode), -1);
          else begin
            int er;
            er = reqQ.pop_front();
            check(int'(reqMode) == er, "R2 R3 R8 request order", int'(reqMode), er);
          end
          for (int p = 0; p < 16; p++) predPix[p*8 +: 8] = 8'(predAt(int'(reqMode), p));
          predValid = 1'b1;
        end
      end else predValid = 1'b0;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!reqValid, "R1 reqValid after reset", int'(reqValid), 0);
    check(!done, "R1 done after reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);

    // macroblock A: mode 5 exact, so the full-search minimum becomes zero
    setNoise(30); noiseLvl[5] = 0;
    runBlock(0, 0, 0, 0, 0, 4, 1, "R2 R5 full", 0);
    // candidate with zero SATD: equal to 2*min, no re-search
    setNoise(30); noiseLvl[1] = 0;
    runBlock(1, 1, 1, 0, 1, 4, 2, "R8 equality R3", 0);
    // noisy reduced block: must re-search
    setNoise(20);
    runBlock(2, 7, 1, 7, 1, 3, 3, "R8 fallback", 0);
    // all ties with zero lambda, ignored start in the middle
    setNoise(0);
    runBlock(3, 3, 1, 3, 1, 0, 4, "R7 R11 tie", 1);
    runBlock(4, 0, 0, 0, 0, 0, 5, "R7 full tie", 0);
    // odd-column-only difference: subsampled SATD is zero
    setNoise(40); oddOnly = 1'b1;
    runBlock(5, 6, 1, 4, 1, 5, 6, "R6 subsample", 0);
    oddOnly = 1'b0;
    // unavailable neighbours, most probable mode is DC
    setNoise(25);
    runBlock(6, 8, 0, 1, 1, 7, 7, "R3 R4 unavailable", 0);

    // macroblock B: minimum must be cleared and rebuilt
    setNoise(25);
    runBlock(0, 0, 0, 0, 0, 10, 8, "R9 new macroblock", 0);
    runBlock(1, 2, 1, 5, 1, 10, 9, "R9 reduced", 0);

    // sweep
    for (int k = 0; k < 40; k++) begin
      int idx;
      idx = k % 16;
      for (int i = 0; i < 9; i++) noiseLvl[i] = (k * 7 + i * 13) % 50;
      runBlock(idx, (k * 5) % 9, (k % 5) != 0, (k * 4 + 1) % 9, (k % 7) != 0,
               (k * 3) % 20, 11 + k, "R4 R5 R9 sweep", 0);
    end

    if (reqQ.size() != 0) check(1'b0, "R2 R3 missing requests", reqQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule